// File: doc/BRIEF.md
# Debounced Wake-Up Controller

This block watches a bank of external wake-up pins and a handful of internal wake sources. It raises a single-cycle wake request for a power-management sequencer when one of them becomes active. The block runs on the slow always-on clock. Each pin can be enabled on its own and given its own active polarity. One shared debounce timer sets how long the set of enabled, active pins must stay active before the request fires. The timer length is selected by a 3-bit code.

Three internal sources also produce a request on the rising edge of their event, each under its own enable: a timer alarm, a calendar alarm and a supply-monitor detection. Software reads sticky status flags and a per-pin snapshot of which pins were active when the debouncer fired. Reading the status register clears it. Access is through a simple word-wide register port with read data registered one cycle after the read strobe.

Top module: `wkc_ctrl`

## Requirements
- R1: After reset, wake_req is 0 and the pin configuration, mode and status registers all read as zero.
- R2: Address 0 is the pin configuration register: bit i (0..15) enables pin i and bit 16+i sets the polarity of pin i. Address 1 is the mode register: bit 0 enables supply-monitor wake, bit 1 enables timer-alarm wake, bit 2 enables calendar-alarm wake, and bits 6:4 hold the debounce code. The other mode bits read as 0. Address 3 reads as 0. Read data appears on bus_rdata one clock after the read strobe.
- R3: A pin whose enable bit is 0 never causes a wake request and never sets any status bit.
- R4: With polarity 0 a pin is active while low. With polarity 1 it is active while high.
- R5: Debounce code 0 needs the active level on a single clock edge. Codes 1, 2, 3, 4 and 5 need 3, 32, 512, 4096 and 32768 consecutive active cycles. Each pin passes through two synchronizer flops, so wake_req first reads high N+2 clock edges after the pin becomes active, where N is the selected length (1 for code 0).
- R6: Debounce codes 6 and 7 behave exactly like code 0.
- R7: If every enabled pin leaves its active state before the interval completes, the debounce count restarts from zero.
- R8: wake_req is high for exactly one cycle per trigger. Pins that stay active trigger only once until all enabled pins have gone inactive.
- R9: Status bit 0 is set by a pin-caused wake and stays set until the status register (address 2) is read. The read returns the value before clearing. A trigger in the same cycle as the read wins.
- R10: Status bits 31:16 hold, for each pin, whether it was enabled and active in the cycle the debouncer fired. They are cleared by a status read.
- R11: A rising edge on the timer alarm or the calendar alarm, with its enable bit set, produces wake_req one clock edge later. With the enable bit clear it has no effect.
- R12: A rising edge on the supply-monitor detection, with its enable set, produces wake_req one edge later and sets sticky status bit 1, which a status read clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wk_pin | input | 16 | External wake-up pins (asynchronous) |
| rtt_alarm | input | 1 | Timer alarm event |
| rtc_alarm | input | 1 | Calendar alarm event |
| smon_det | input | 1 | Supply-monitor detection event |
| wake_req | output | 1 | Single-cycle wake request |

## Verification
Most internal faults show at the ports as a change in the latency of wake_req. A debounce counter that does not restart, or that compares against the wrong limit, moves the first high cycle of wake_req away from N+2 edges after the pin change. That is visible within one debounce interval. A stuck fired flag shows up as a second pulse, or as a missing pulse on the next activation. A wrong snapshot or sticky flag shows up on the next status read. A failed read-clear shows up on the read after that, so every trigger is followed by two status reads.

// File: rtl/wkc_pkg.sv
`timescale 1ns/1ps
package wkc_pkg;
  localparam int unsigned CNT_W = 17;

  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_MODE = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } wk_addr_e;

  // mode register field positions
  localparam int unsigned M_SM  = 0;
  localparam int unsigned M_RTT = 1;
  localparam int unsigned M_RTC = 2;
  localparam int unsigned M_DBC = 4;

  // status register field positions
  localparam int unsigned S_PIN = 0;
  localparam int unsigned S_SM  = 1;

  // interval lengths for codes 1..5
  localparam int unsigned LEN_C1 = 3;
  localparam int unsigned LEN_C2 = 32;
  localparam int unsigned LEN_C3 = 512;
  localparam int unsigned LEN_C4 = 4096;
  localparam int unsigned LEN_C5 = 32768;

  // count value at which the debouncer fires (length minus one)
  function automatic logic [CNT_W-1:0] dbc_limit(input logic [2:0] code);
    case (code)
      3'd1:    dbc_limit = CNT_W'(LEN_C1 - 1);
      3'd2:    dbc_limit = CNT_W'(LEN_C2 - 1);
      3'd3:    dbc_limit = CNT_W'(LEN_C3 - 1);
      3'd4:    dbc_limit = CNT_W'(LEN_C4 - 1);
      3'd5:    dbc_limit = CNT_W'(LEN_C5 - 1);
      default: dbc_limit = '0;
    endcase
  endfunction
endpackage

// File: rtl/wkc_sync.sv
`timescale 1ns/1ps
module wkc_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wkc_debounce.sv
`timescale 1ns/1ps
module wkc_debounce
  import wkc_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] act,
  input  logic [2:0]      code,
  output logic            any_act,
  output logic            fire
);
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;
  logic [CNT_W-1:0] lim;

  assign any_act = |act;
  assign lim     = dbc_limit(code);
  assign fire    = any_act && !fired_q && (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (!any_act) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (fire) begin
      cnt_q   <= '0;
      fired_q <= 1'b1;
    end else if (!fired_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wkc_isrc.sv
`timescale 1ns/1ps
module wkc_isrc #(
  parameter int unsigned NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en,
  output logic            fire_any,
  output logic            fire_first
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) prev_q[i] <= 1'b0;
      else     prev_q[i] <= evt[i] & en[i];
    end
    assign rise[i] = evt[i] & en[i] & ~prev_q[i];
  end

  assign fire_any   = |rise;
  assign fire_first = rise[0];
endmodule

// File: rtl/wkc_ctrl.sv
`timescale 1ns/1ps
module wkc_ctrl
  import wkc_pkg::*;
#(
  parameter int unsigned NPIN = 16,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NPIN-1:0] wk_pin,
  input  logic            rtt_alarm,
  input  logic            rtc_alarm,
  input  logic            smon_det,
  output logic            wake_req
);
  localparam int unsigned SNAP_LSB = DW / 2;

  logic [NPIN-1:0] pin_en, pin_pol, pin_s, act, snap_q;
  logic            sm_en, rtt_en, rtc_en;
  logic [2:0]      dbc_code;
  logic            any_act, pin_fire, src_fire, sm_fire;
  logic            st_pin_q, st_sm_q;
  logic            stat_rd;

  assign stat_rd = bus_rd && (wk_addr_e'(bus_addr) == A_STAT);

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en   <= '0;
      pin_pol  <= '0;
      sm_en    <= 1'b0;
      rtt_en   <= 1'b0;
      rtc_en   <= 1'b0;
      dbc_code <= '0;
    end else if (bus_wr) begin
      case (wk_addr_e'(bus_addr))
        A_CFG: begin
          pin_en  <= bus_wdata[NPIN-1:0];
          pin_pol <= bus_wdata[SNAP_LSB +: NPIN];
        end
        A_MODE: begin
          sm_en    <= bus_wdata[M_SM];
          rtt_en   <= bus_wdata[M_RTT];
          rtc_en   <= bus_wdata[M_RTC];
          dbc_code <= bus_wdata[M_DBC +: 3];
        end
        default: ;
      endcase
    end
  end

  wkc_sync #(.W(NPIN), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (wk_pin),
    .q   (pin_s)
  );

  assign act = pin_en & ~(pin_s ^ pin_pol);

  wkc_debounce #(.NPIN(NPIN)) u_dbc (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .code    (dbc_code),
    .any_act (any_act),
    .fire    (pin_fire)
  );

  wkc_isrc #(.NSRC(3)) u_isrc (
    .clk        (clk),
    .rst        (rst),
    .evt        ({rtc_alarm, rtt_alarm, smon_det}),
    .en         ({rtc_en, rtt_en, sm_en}),
    .fire_any   (src_fire),
    .fire_first (sm_fire)
  );

  // status, snapshot and request
  always_ff @(posedge clk) begin
    if (rst) begin
      st_pin_q <= 1'b0;
      st_sm_q  <= 1'b0;
      snap_q   <= '0;
      wake_req <= 1'b0;
    end else begin
      st_pin_q <= pin_fire | (st_pin_q & ~stat_rd);
      st_sm_q  <= sm_fire  | (st_sm_q  & ~stat_rd);
      if (pin_fire)     snap_q <= act;
      else if (stat_rd) snap_q <= '0;
      wake_req <= pin_fire | src_fire;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (wk_addr_e'(bus_addr))
        A_CFG: begin
          bus_rdata[NPIN-1:0]         <= pin_en;
          bus_rdata[SNAP_LSB +: NPIN] <= pin_pol;
        end
        A_MODE: begin
          bus_rdata[M_SM]      <= sm_en;
          bus_rdata[M_RTT]     <= rtt_en;
          bus_rdata[M_RTC]     <= rtc_en;
          bus_rdata[M_DBC +: 3] <= dbc_code;
        end
        A_STAT: begin
          bus_rdata[S_PIN]            <= st_pin_q;
          bus_rdata[S_SM]             <= st_sm_q;
          bus_rdata[SNAP_LSB +: NPIN] <= snap_q;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wkc_ctrl_chk.sv
`timescale 1ns/1ps
module wkc_ctrl_chk
  import wkc_pkg::*;
#(
  parameter int unsigned NPIN = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            any_act,
  input logic            pin_fire,
  input logic            src_fire,
  input logic            stat_rd,
  input logic [2:0]      dbc_code,
  input logic [NPIN-1:0] pin_en,
  input logic [NPIN-1:0] snap_q,
  input logic            st_pin_q,
  input logic            st_sm_q,
  input logic            wake_req
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !any_act) run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  AST_FIRE_TO_WAKE: assert property (@(posedge clk) disable iff (rst)
    pin_fire |=> wake_req); // R8
  AST_WAKE_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> $past(pin_fire || src_fire)); // R8
  AST_DBC_HELD_LONG: assert property (@(posedge clk) disable iff (rst)
    pin_fire |-> (run_q >= dbc_limit(dbc_code))); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !pin_fire && !src_fire) |=> (!st_pin_q && !st_sm_q && snap_q == '0)); // R9
  AST_PIN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (st_pin_q && !stat_rd) |=> st_pin_q); // R9
  AST_SNAP_ENABLED: assert property (@(posedge clk) disable iff (rst)
    pin_fire |=> ((snap_q & ~$past(pin_en)) == '0)); // R10
endmodule

bind wkc_ctrl wkc_ctrl_chk #(.NPIN(NPIN)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .any_act  (any_act),
  .pin_fire (pin_fire),
  .src_fire (src_fire),
  .stat_rd  (stat_rd),
  .dbc_code (dbc_code),
  .pin_en   (pin_en),
  .snap_q   (snap_q),
  .st_pin_q (st_pin_q),
  .st_sm_q  (st_sm_q),
  .wake_req (wake_req)
);

// File: tb/wkc_ctrl_tb_top.sv
`timescale 1ns/1ps
module wkc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] wk_pin = '0;
  logic        rtt_alarm = 1'b0, rtc_alarm = 1'b0, smon_det = 1'b0;
  logic        wake_req;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  wkc_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wk_pin(wk_pin),
    .rtt_alarm(rtt_alarm), .rtc_alarm(rtc_alarm), .smon_det(smon_det),
    .wake_req(wake_req)
  );

  function automatic int exp_len(input logic [2:0] code);
    case (code)
      3'd1: return 3;
      3'd2: return 32;
      3'd3: return 512;
      3'd4: return 4096;
      3'd5: return 32768;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watch for lim negedges, record first high index and pulse count
  task automatic watch(input int lim, output int first, output int pulses);
    first = 0; pulses = 0;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (wake_req) begin
        pulses++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic latency_case(input logic [2:0] code, input string req);
    logic [31:0] d;
    int first, pulses, n;
    n = exp_len(code);
    wr(2'd1, {25'd0, code, 4'd0});
    wr(2'd0, 32'h0001_0001);
    wk_pin = '0;
    idle(4);
    rd(2'd2, d);
    @(negedge clk);
    wk_pin[0] = 1'b1;
    watch(n + 12, first, pulses);
    chk(first == n + 2, req, first, n + 2);
    chk(pulses == 1, "R8", pulses, 1);
    rd(2'd2, d);
    chk(d == 32'h0001_0001, "R10", d, 32'h0001_0001);
    rd(2'd2, d);
    chk(d == 32'h0, "R9", d, 0);
    wk_pin = '0;
    idle(4);
  endtask

  initial begin
    logic [31:0] d;
    int first, pulses;
    void'($urandom(32'd5150));
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    chk(wake_req == 1'b0, "R1", wake_req, 0);
    rd(2'd0, d); chk(d == 0, "R1", d, 0);
    rd(2'd1, d); chk(d == 0, "R1", d, 0);
    rd(2'd2, d); chk(d == 0, "R1", d, 0);

    wr(2'd0, 32'hA5A5_5A5A);
    rd(2'd0, d); chk(d == 32'hA5A5_5A5A, "R2", d, 32'hA5A5_5A5A);
    wr(2'd1, 32'hFFFF_FF88);
    rd(2'd1, d); chk(d == 32'h0000_0000, "R2", d, 0);
    rd(2'd3, d); chk(d == 0, "R2", d, 0);

    latency_case(3'd0, "R5");
    latency_case(3'd1, "R5");
    latency_case(3'd2, "R5");
    latency_case(3'd3, "R5");
    latency_case(3'd5, "R5");
    latency_case(3'd6, "R6");
    latency_case(3'd7, "R6");

    // R4: active-low pin 1, code 0
    wr(2'd1, 32'h0);
    wk_pin = 16'hFFFF;
    wr(2'd0, 32'h0000_0002);
    idle(4);
    rd(2'd2, d);
    @(negedge clk);
    wk_pin[1] = 1'b0;
    watch(10, first, pulses);
    chk(first == 3, "R4", first, 3);
    rd(2'd2, d); chk(d == 32'h0002_0001, "R4", d, 32'h0002_0001);
    wk_pin = 16'hFFFF;
    idle(4);

    // R3: all pins disabled
    wr(2'd0, 32'hFFFF_0000);
    idle(4);
    rd(2'd2, d);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      wk_pin = ~wk_pin;
      watch(5, first, pulses);
      chk(pulses == 0, "R3", pulses, 0);
    end
    rd(2'd2, d); chk(d == 0, "R3", d, 0);

    // R7: restart with code 1 (3 cycles)
    wr(2'd1, 32'h0000_0010);
    wr(2'd0, 32'h0001_0001);
    wk_pin = '0;
    idle(4);
    rd(2'd2, d);
    @(negedge clk);
    wk_pin[0] = 1'b1;
    idle(2);
    wk_pin[0] = 1'b0;
    watch(6, first, pulses);
    chk(pulses == 0, "R7", pulses, 0);
    wk_pin[0] = 1'b1;
    watch(12, first, pulses);
    chk(first == 5, "R7", first, 5);
    wk_pin = '0;
    idle(4);

    // R11: timer and calendar alarms
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0000_0002);
    rd(2'd2, d);
    @(negedge clk);
    rtt_alarm = 1'b1;
    watch(8, first, pulses);
    chk(first == 1 && pulses == 1, "R11", first, 1);
    rtt_alarm = 1'b0;
    @(negedge clk);
    rtc_alarm = 1'b1;
    watch(8, first, pulses);
    chk(pulses == 0, "R11", pulses, 0);
    rtc_alarm = 1'b0;
    wr(2'd1, 32'h0000_0004);
    @(negedge clk);
    rtc_alarm = 1'b1;
    watch(8, first, pulses);
    chk(first == 1 && pulses == 1, "R11", first, 1);
    rtc_alarm = 1'b0;
    rd(2'd2, d); chk(d == 0, "R11", d, 0);

    // R12: supply monitor
    @(negedge clk);
    smon_det = 1'b1;
    watch(6, first, pulses);
    chk(pulses == 0, "R12", pulses, 0);
    smon_det = 1'b0;
    rd(2'd2, d); chk(d == 0, "R12", d, 0);
    wr(2'd1, 32'h0000_0001);
    @(negedge clk);
    smon_det = 1'b1;
    watch(6, first, pulses);
    chk(first == 1 && pulses == 1, "R12", first, 1);
    smon_det = 1'b0;
    rd(2'd2, d); chk(d == 32'h2, "R12", d, 2);
    rd(2'd2, d); chk(d == 0, "R12", d, 0);

    // random configurations and pin patterns
    for (int it = 0; it < 40; it++) begin
      logic [15:0] en, pol, pins, actv;
      logic [2:0]  code;
      int n;
      en   = 16'($urandom);
      pol  = 16'($urandom);
      pins = 16'($urandom);
      case ($urandom % 4)
        0: code = 3'd0;
        1: code = 3'd1;
        2: code = 3'd6;
        default: code = 3'd7;
      endcase
      n = exp_len(code);
      actv = en & ~(pins ^ pol);
      wr(2'd1, {25'd0, code, 4'd0});
      wk_pin = ~pol;
      wr(2'd0, {pol, en});
      idle(6);
      rd(2'd2, d);
      @(negedge clk);
      wk_pin = pins;
      watch(n + 12, first, pulses);
      if (actv != 0) begin
        chk(first == n + 2, "R5", first, n + 2);
        chk(pulses == 1, "R8", pulses, 1);
        rd(2'd2, d);
        chk(d == {actv, 16'h0001}, "R10", d, {actv, 16'h0001});
      end else begin
        chk(pulses == 0, "R3", pulses, 0);
        rd(2'd2, d);
        chk(d == 0, "R3", d, 0);
      end
      wk_pin = ~pol;
      idle(4);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule